// File: doc/BRIEF.md
# Rename-Stage Pair Fusion Detector

This block looks at one bundle of up to eight decoded micro-ops, held in program order one per slot, and merges selected neighbouring pairs into a single fused micro-op. Two pairings are handled. The first is an add-like op followed by a register-indirect jump that writes nothing, which is the usual stack adjust or result move before a return. The second is a load-immediate followed by a conditional branch that reads the loaded register. The branch may read that register on either side of the comparison, so this pairing has a left form and a right form. The second op of a pair absorbs the first op's destination, immediate and source. The first op stays in its slot as a placeholder that writes nothing and is already complete, so later stages never issue it.

A qualification flag travels from slot to slot. Each slot may start a pair, and it completes one only when its predecessor in the same bundle started one. Slot 0 always sees an empty flag, so pairs never span bundles. All matching happens combinationally in one cycle, and the rewritten slots are registered. The branch's own target offset is assumed to travel on a separate path and is not handled here.

Top module: `fusion_pairer`

## Requirements
- R1: Outputs are registered and show a bundle exactly one clock edge after it is presented. While rst_n is low, every output field is zero.
- R2: Add/jump fusion. A valid slot holding ADDI (ctrl 1), or ADD (ctrl 2) with rs1 or rs2 equal to 0, that has wr=1 and rd≠0 starts a pair. If the next slot holds a jump (ctrl 3) with wr=0 and imm=0, that slot becomes ctrl 4 with rd set to the add's rd, wr=1, rs1 unchanged, and rs2 set to the add's source. The source is rs1 for ADDI. For ADD it is rs2 when rs1 is 0 and rs1 otherwise. imm becomes the ADDI immediate, or 0 for ADD.
- R3: The add/jump pair is not formed when the add's rd equals the jump's rs1.
- R4: Right-side branch fusion. A valid ADDI with rs1=0, wr=1 and rd≠0 is followed by a branch (ctrl[4:3]=01, condition in ctrl[2:0]) whose rs2 equals the loaded rd and whose rs1 does not. The branch becomes ctrl {11,cond} with rs2 cleared to 0, imm set to the load's immediate, rd set to the loaded rd, and wr=1.
- R5: Left-side branch fusion. When the branch's rs1 equals the loaded rd, the branch becomes ctrl {10,cond} with rs1 cleared to 0 and rd, wr and imm set as in R4. If both operands match, the left form is used.
- R6: The absorbed first op keeps all its fields except that wr becomes 0 and done becomes 1. No slot is both fused and absorbed.
- R7: Slot 0 is never fused and slot SLOTS-1 is never absorbed. An op at the end of one bundle never pairs with the start of the next.
- R8: An op belongs to at most one pair, and an op can only pair with the op directly after it. In a run of qualifying first ops, only the one right before the second op is absorbed.
- R9: An invalid slot never starts or completes a pair. Its valid bit is passed through as 0 and its done bit is 0.
- R10: Slots not involved in a pair pass through unchanged with done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | SLOTS | Per-slot valid |
| in_ctrl | input | SLOTS×5 | Per-slot control code |
| in_rd | input | SLOTS×5 | Destination register |
| in_rs1 | input | SLOTS×5 | First source register |
| in_rs2 | input | SLOTS×5 | Second source register |
| in_imm | input | SLOTS×32 | Immediate |
| in_wr | input | SLOTS | Op writes rd |
| out_vld | output | SLOTS | Registered valid |
| out_ctrl | output | SLOTS×5 | Rewritten control code |
| out_rd | output | SLOTS×5 | Rewritten destination |
| out_rs1 | output | SLOTS×5 | Rewritten first source |
| out_rs2 | output | SLOTS×5 | Rewritten second source |
| out_imm | output | SLOTS×32 | Rewritten immediate |
| out_wr | output | SLOTS | Rewritten write flag |
| out_done | output | SLOTS | Absorbed, complete for commit |

## Verification
The bench places every pairing at every slot position, on both branch sides, and with both operands matching. A design that sets the side bit wrongly, or clears the wrong register field, would show a mismatched ctrl or source field. The bench also covers the jump whose target register is the add's destination; a design that ignored that rule would fuse it and corrupt the return address. Runs of consecutive first ops, an invalid slot in the middle of a candidate pair, and a pair split by the bundle edge are all exercised. A design whose flag leaked across those points would absorb the wrong slot, or one slot too many. Weighted random bundles then fill the gaps against a behavioural model.

// File: rtl/fusion_pkg.sv
package fusion_pkg;
  parameter int unsigned REG_W  = 5;
  parameter int unsigned IMM_W  = 32;
  localparam int unsigned CTRL_W = 5;

  typedef logic [CTRL_W-1:0] ctrl_t;

  localparam ctrl_t OP_MISC  = 5'd0;
  localparam ctrl_t OP_ADDI  = 5'd1;
  localparam ctrl_t OP_ADD   = 5'd2;
  localparam ctrl_t OP_JREG  = 5'd3;
  localparam ctrl_t OP_FJREG = 5'd4;

  typedef struct packed {
    logic             vld;
    ctrl_t            ctrl;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [IMM_W-1:0] imm;
    logic             wr;
    logic             done;
  } uop_t;

  function automatic logic is_branch(input ctrl_t c);
    return c[4:3] == 2'b01;
  endfunction

  function automatic logic is_fused(input ctrl_t c);
    return (c == OP_FJREG) || c[4];
  endfunction

  // side = 1: immediate replaces the right operand
  function automatic ctrl_t fused_branch(input ctrl_t c, input logic side);
    return {1'b1, side, c[2:0]};
  endfunction

  // source register carried by an add-like op
  function automatic logic [REG_W-1:0] add_source(input ctrl_t c,
                                                  input logic [REG_W-1:0] a,
                                                  input logic [REG_W-1:0] b);
    if (c == OP_ADDI) return a;
    return (a == '0) ? b : a;
  endfunction
endpackage

// File: rtl/fusion_classify.sv
module fusion_classify
  import fusion_pkg::*;
(
  input  uop_t             cur,
  output logic             head_add,
  output logic             head_li,
  output logic [REG_W-1:0] head_src,
  output logic [IMM_W-1:0] head_imm,
  output logic             tail_ret,
  output logic             tail_br
);
  logic writes_real;
  logic add_x0;

  always_comb begin
    writes_real = cur.vld && cur.wr && (cur.rd != '0);
    add_x0      = (cur.ctrl == OP_ADD) && ((cur.rs1 == '0) || (cur.rs2 == '0));
    head_add    = writes_real && ((cur.ctrl == OP_ADDI) || add_x0);
    head_li     = writes_real && (cur.ctrl == OP_ADDI) && (cur.rs1 == '0);
    head_src    = add_source(cur.ctrl, cur.rs1, cur.rs2);
    head_imm    = (cur.ctrl == OP_ADDI) ? cur.imm : '0;
    tail_ret    = cur.vld && (cur.ctrl == OP_JREG) && !cur.wr && (cur.imm == '0);
    tail_br     = cur.vld && is_branch(cur.ctrl);
  end
endmodule

// File: rtl/fusion_merge.sv
module fusion_merge
  import fusion_pkg::*;
(
  input  uop_t             cur,
  input  logic             head_add,
  input  logic             head_li,
  input  logic             tail_ret,
  input  logic             tail_br,
  input  logic             up_add,
  input  logic             up_li,
  input  logic [REG_W-1:0] up_rd,
  input  logic [REG_W-1:0] up_src,
  input  logic [IMM_W-1:0] up_imm,
  output logic             fused,
  output uop_t             res,
  output logic             dn_add,
  output logic             dn_li
);
  logic hit_ret;
  logic hit_left;
  logic hit_right;

  always_comb begin
    hit_ret   = tail_ret && up_add && (up_rd != cur.rs1);
    hit_left  = tail_br && up_li && (cur.rs1 == up_rd);
    hit_right = tail_br && up_li && !hit_left && (cur.rs2 == up_rd);
    fused     = hit_ret || hit_left || hit_right;

    res = cur;
    if (fused) begin
      res.rd  = up_rd;
      res.wr  = 1'b1;
      res.imm = up_imm;
    end
    if (hit_ret) begin
      res.ctrl = OP_FJREG;
      res.rs2  = up_src;
    end
    if (hit_left) begin
      res.ctrl = fused_branch(cur.ctrl, 1'b0);
      res.rs1  = '0;
    end
    if (hit_right) begin
      res.ctrl = fused_branch(cur.ctrl, 1'b1);
      res.rs2  = '0;
    end

    // a slot that closed a pair cannot open another
    dn_add = head_add && !fused;
    dn_li  = head_li && !fused;
  end
endmodule

// File: rtl/fusion_pairer.sv
module fusion_pairer
  import fusion_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            in_vld,
  input  logic [SLOTS-1:0][CTRL_W-1:0] in_ctrl,
  input  logic [SLOTS-1:0][REG_W-1:0] in_rd,
  input  logic [SLOTS-1:0][REG_W-1:0] in_rs1,
  input  logic [SLOTS-1:0][REG_W-1:0] in_rs2,
  input  logic [SLOTS-1:0][IMM_W-1:0] in_imm,
  input  logic [SLOTS-1:0]            in_wr,
  output logic [SLOTS-1:0]            out_vld,
  output logic [SLOTS-1:0][CTRL_W-1:0] out_ctrl,
  output logic [SLOTS-1:0][REG_W-1:0] out_rd,
  output logic [SLOTS-1:0][REG_W-1:0] out_rs1,
  output logic [SLOTS-1:0][REG_W-1:0] out_rs2,
  output logic [SLOTS-1:0][IMM_W-1:0] out_imm,
  output logic [SLOTS-1:0]            out_wr,
  output logic [SLOTS-1:0]            out_done
);
  localparam int unsigned LAST = SLOTS - 1;

  uop_t                        cur     [SLOTS];
  uop_t                        merged  [SLOTS];
  uop_t                        final_q [SLOTS];
  uop_t                        final_d [SLOTS];
  logic [SLOTS-1:0]            head_add, head_li, tail_ret, tail_br;
  logic [SLOTS-1:0][REG_W-1:0] head_src;
  logic [SLOTS-1:0][IMM_W-1:0] head_imm;
  logic [SLOTS:0]              link_add, link_li;
  logic [SLOTS-1:0]            fuse_hit;
  logic [SLOTS-1:0]            absorb;

  assign link_add[0] = 1'b0;
  assign link_li[0]  = 1'b0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [REG_W-1:0] up_rd;
    logic [REG_W-1:0] up_src;
    logic [IMM_W-1:0] up_imm;

    always_comb begin
      cur[i].vld  = in_vld[i];
      cur[i].ctrl = in_ctrl[i];
      cur[i].rd   = in_rd[i];
      cur[i].rs1  = in_rs1[i];
      cur[i].rs2  = in_rs2[i];
      cur[i].imm  = in_imm[i];
      cur[i].wr   = in_wr[i];
      cur[i].done = 1'b0;
    end

    if (i == 0) begin : g_first
      assign up_rd  = '0;
      assign up_src = '0;
      assign up_imm = '0;
    end else begin : g_rest
      assign up_rd  = in_rd[i-1];
      assign up_src = head_src[i-1];
      assign up_imm = head_imm[i-1];
    end

    fusion_classify u_cls (
      .cur      (cur[i]),
      .head_add (head_add[i]),
      .head_li  (head_li[i]),
      .head_src (head_src[i]),
      .head_imm (head_imm[i]),
      .tail_ret (tail_ret[i]),
      .tail_br  (tail_br[i])
    );

    fusion_merge u_mrg (
      .cur      (cur[i]),
      .head_add (head_add[i]),
      .head_li  (head_li[i]),
      .tail_ret (tail_ret[i]),
      .tail_br  (tail_br[i]),
      .up_add   (link_add[i]),
      .up_li    (link_li[i]),
      .up_rd    (up_rd),
      .up_src   (up_src),
      .up_imm   (up_imm),
      .fused    (fuse_hit[i]),
      .res      (merged[i]),
      .dn_add   (link_add[i+1]),
      .dn_li    (link_li[i+1])
    );

    if (i == LAST) begin : g_tail
      assign absorb[i] = 1'b0;
    end else begin : g_mid
      assign absorb[i] = fuse_hit[i+1];
    end

    always_comb begin
      final_d[i] = merged[i];
      if (absorb[i]) begin
        final_d[i].wr   = 1'b0;
        final_d[i].done = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) final_q[i] <= '0;
      else        final_q[i] <= final_d[i];
    end

    assign out_vld[i]  = final_q[i].vld;
    assign out_ctrl[i] = final_q[i].ctrl;
    assign out_rd[i]   = final_q[i].rd;
    assign out_rs1[i]  = final_q[i].rs1;
    assign out_rs2[i]  = final_q[i].rs2;
    assign out_imm[i]  = final_q[i].imm;
    assign out_wr[i]   = final_q[i].wr;
    assign out_done[i] = final_q[i].done;
  end
endmodule

// File: rtl/fusion_pairer_chk.sv
module fusion_pairer_chk
  import fusion_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [SLOTS-1:0]             q_vld,
  input logic [SLOTS-1:0][CTRL_W-1:0] q_ctrl,
  input logic [SLOTS-1:0][REG_W-1:0]  q_rd,
  input logic [SLOTS-1:0][REG_W-1:0]  q_rs1,
  input logic [SLOTS-1:0]             q_wr,
  input logic [SLOTS-1:0]             q_done
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    // R6
    absorb_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_done[i] |-> !q_wr[i]);
    // R8
    single_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_done[i] |-> !is_fused(q_ctrl[i]));
    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !q_vld[i] |-> !q_done[i]);
    // R3
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld[i] && q_ctrl[i] == OP_FJREG) |-> (q_rd[i] != q_rs1[i]));
    if (i > 0) begin : g_pair
      // R6
      pair_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld[i] && is_fused(q_ctrl[i])) |-> (q_done[i-1] && q_wr[i]));
      // R9
      gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld[i-1] |-> !is_fused(q_ctrl[i]));
    end
  end

  // R7
  lead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld[0] |-> !is_fused(q_ctrl[0]));
  // R7
  tail_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_done[SLOTS-1]);
endmodule

bind fusion_pairer fusion_pairer_chk #(.SLOTS(SLOTS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .q_vld  (out_vld),
  .q_ctrl (out_ctrl),
  .q_rd   (out_rd),
  .q_rs1  (out_rs1),
  .q_wr   (out_wr),
  .q_done (out_done)
);

// File: tb/test_fusion_pairer.sv
`timescale 1ns/1ps
module test_fusion_pairer;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]       in_vld, in_wr;
  logic [N-1:0][4:0]  in_ctrl, in_rd, in_rs1, in_rs2;
  logic [N-1:0][31:0] in_imm;
  logic [N-1:0]       out_vld, out_wr, out_done;
  logic [N-1:0][4:0]  out_ctrl, out_rd, out_rs1, out_rs2;
  logic [N-1:0][31:0] out_imm;

  logic        e_vld[N], e_wr[N], e_done[N];
  logic [4:0]  e_ctrl[N], e_rd[N], e_rs1[N], e_rs2[N];
  logic [31:0] e_imm[N];

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  fusion_pairer #(.SLOTS(N)) i_fusion_pairer (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_ctrl(in_ctrl), .in_rd(in_rd), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .in_imm(in_imm), .in_wr(in_wr),
    .out_vld(out_vld), .out_ctrl(out_ctrl), .out_rd(out_rd), .out_rs1(out_rs1),
    .out_rs2(out_rs2), .out_imm(out_imm), .out_wr(out_wr), .out_done(out_done)
  );

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic clear_bundle();
    for (int k = 0; k < N; k++) begin
      in_vld[k]  = 1'b1;
      in_ctrl[k] = 5'd0;
      in_rd[k]   = 5'(11 + k);
      in_rs1[k]  = 5'(20 + k);
      in_rs2[k]  = 5'(3 + k);
      in_imm[k]  = 32'(100 + 7 * k);
      in_wr[k]   = 1'b1;
    end
  endtask

  task automatic put(int k, logic [4:0] c, int rd, int r1, int r2,
                     logic [31:0] imm, logic wr);
    in_ctrl[k] = c;
    in_rd[k]   = 5'(rd);
    in_rs1[k]  = 5'(r1);
    in_rs2[k]  = 5'(r2);
    in_imm[k]  = imm;
    in_wr[k]   = wr;
  endtask

  // behavioural pairing rules
  task automatic model();
    bit open_add, open_li, hit;
    logic [4:0]  h_rd, h_src;
    logic [31:0] h_imm;
    open_add = 0; open_li = 0; h_rd = 0; h_src = 0; h_imm = 0;
    for (int k = 0; k < N; k++) begin
      e_vld[k] = in_vld[k]; e_ctrl[k] = in_ctrl[k]; e_rd[k] = in_rd[k];
      e_rs1[k] = in_rs1[k]; e_rs2[k] = in_rs2[k]; e_imm[k] = in_imm[k];
      e_wr[k] = in_wr[k]; e_done[k] = 1'b0;
    end
    for (int k = 0; k < N; k++) begin
      hit = 0;
      if (in_vld[k]) begin
        if (open_add && in_ctrl[k] == 5'd3 && !in_wr[k] && in_imm[k] == 0
            && in_rs1[k] != h_rd) begin
          hit = 1; e_ctrl[k] = 5'd4; e_rs2[k] = h_src;
        end else if (open_li && in_ctrl[k][4:3] == 2'b01 && in_rs1[k] == h_rd) begin
          hit = 1; e_ctrl[k] = {2'b10, in_ctrl[k][2:0]}; e_rs1[k] = 0;
        end else if (open_li && in_ctrl[k][4:3] == 2'b01 && in_rs2[k] == h_rd) begin
          hit = 1; e_ctrl[k] = {2'b11, in_ctrl[k][2:0]}; e_rs2[k] = 0;
        end
      end
      if (hit) begin
        e_rd[k] = h_rd; e_wr[k] = 1'b1; e_imm[k] = h_imm;
        e_wr[k-1] = 1'b0; e_done[k-1] = 1'b1;
      end
      open_add = 0; open_li = 0;
      if (in_vld[k] && !hit && in_wr[k] && in_rd[k] != 0) begin
        if (in_ctrl[k] == 5'd1) begin
          open_add = 1; open_li = (in_rs1[k] == 0);
          h_src = in_rs1[k]; h_imm = in_imm[k];
        end else if (in_ctrl[k] == 5'd2 && (in_rs1[k] == 0 || in_rs2[k] == 0)) begin
          open_add = 1;
          h_src = (in_rs1[k] == 0) ? in_rs2[k] : in_rs1[k]; h_imm = 0;
        end
        h_rd = in_rd[k];
      end
    end
  endtask

  task automatic compare(string tag);
    logic [54:0] act, exp;
    for (int k = 0; k < N; k++) begin
      checks++;
      act = {out_vld[k], out_ctrl[k], out_rd[k], out_rs1[k], out_rs2[k],
             out_imm[k], out_wr[k], out_done[k]};
      exp = {e_vld[k], e_ctrl[k], e_rd[k], e_rs1[k], e_rs2[k],
             e_imm[k], e_wr[k], e_done[k]};
      if (act !== exp) begin
        errors++;
        $display("FAIL %s slot %0d: actual %h expected %h", tag, k, act, exp);
      end
    end
  endtask

  // inputs set away from the edge; result appears after one rising edge
  task automatic run(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clear_bundle();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < N; k++) begin
      e_vld[k] = 0; e_ctrl[k] = 0; e_rd[k] = 0; e_rs1[k] = 0; e_rs2[k] = 0;
      e_imm[k] = 0; e_wr[k] = 0; e_done[k] = 0;
    end
    compare("R1 reset");
    rst_n = 1'b1;
    run("R1 latency");

    // R2 / R6: add then return at every position
    for (int p = 0; p < N - 1; p++) begin
      clear_bundle();
      put(p, 5'd1, 2, 2, 9, 32'd40, 1'b1);
      put(p + 1, 5'd3, 0, 1, 0, 32'd0, 1'b0);
      run("R2 R6 addi+jump");
    end
    clear_bundle();
    put(2, 5'd2, 10, 0, 8, 32'd77, 1'b1);
    put(3, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    put(5, 5'd2, 12, 8, 0, 32'd5, 1'b1);
    put(6, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    run("R2 add-x0 move");
    clear_bundle();
    put(1, 5'd1, 2, 2, 0, 32'd16, 1'b1);
    put(2, 5'd3, 0, 1, 0, 32'd4, 1'b0);
    put(4, 5'd1, 2, 2, 0, 32'd16, 1'b1);
    put(5, 5'd3, 7, 1, 0, 32'd0, 1'b1);
    run("R2 jump with offset or link");

    // R3: add destination is the jump target
    clear_bundle();
    put(3, 5'd1, 1, 1, 0, 32'd8, 1'b1);
    put(4, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    run("R3 target conflict");

    // R4 / R5: load-immediate then branch, both sides, all positions
    for (int p = 0; p < N - 1; p++) begin
      clear_bundle();
      put(p, 5'd1, 10, 0, 0, 32'd5, 1'b1);
      put(p + 1, {2'b01, 3'(p)}, 0, 11, 10, 32'd64, 1'b0);
      run("R4 branch right");
      clear_bundle();
      put(p, 5'd1, 10, 0, 0, 32'd5, 1'b1);
      put(p + 1, {2'b01, 3'(p + 1)}, 0, 10, 11, 32'd64, 1'b0);
      run("R5 branch left");
    end
    clear_bundle();
    put(4, 5'd1, 6, 0, 0, 32'hFFFF_FFF0, 1'b1);
    put(5, 5'd9, 0, 6, 6, 32'd8, 1'b0);
    run("R5 both operands");
    clear_bundle();
    put(4, 5'd1, 6, 3, 0, 32'd9, 1'b1);
    put(5, 5'd8, 0, 6, 1, 32'd8, 1'b0);
    put(1, 5'd1, 6, 0, 0, 32'd9, 1'b1);
    put(2, 5'd8, 0, 7, 1, 32'd8, 1'b0);
    run("R4 no match");

    // R7: bundle edge
    clear_bundle();
    put(7, 5'd1, 2, 2, 0, 32'd40, 1'b1);
    run("R7 last slot add");
    clear_bundle();
    put(0, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    run("R7 first slot jump");

    // R8: runs of first ops, doubled second ops
    clear_bundle();
    put(1, 5'd1, 2, 2, 0, 32'd8, 1'b1);
    put(2, 5'd1, 3, 3, 0, 32'd12, 1'b1);
    put(3, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    put(4, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    run("R8 addi addi jump jump");
    clear_bundle();
    put(4, 5'd1, 10, 0, 0, 32'd1, 1'b1);
    put(5, 5'd1, 11, 0, 0, 32'd2, 1'b1);
    put(6, 5'd8, 0, 10, 12, 32'd0, 1'b0);
    put(7, 5'd8, 0, 11, 12, 32'd0, 1'b0);
    run("R8 li li branch branch");

    // R9: invalid slots
    clear_bundle();
    put(3, 5'd1, 2, 2, 0, 32'd8, 1'b1);
    put(4, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    in_vld[3] = 1'b0;
    run("R9 invalid first");
    clear_bundle();
    put(3, 5'd1, 2, 2, 0, 32'd8, 1'b1);
    put(4, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    in_vld[4] = 1'b0;
    run("R9 invalid second");

    // R10: mixed traffic with nothing to pair
    clear_bundle();
    put(0, 5'd2, 4, 5, 6, 32'd3, 1'b1);
    put(1, 5'd1, 0, 0, 0, 32'd3, 1'b1);
    put(2, 5'd3, 0, 1, 0, 32'd0, 1'b0);
    put(3, 5'd1, 5, 0, 0, 32'd3, 1'b0);
    put(4, 5'd8, 0, 5, 1, 32'd0, 1'b0);
    run("R10 pass through");

    // R10: weighted random bundles
    for (int v = 0; v < 3000; v++) begin
      for (int k = 0; k < N; k++) begin
        int r;
        r = int'($urandom % 10);
        if (r < 3)      in_ctrl[k] = 5'd1;
        else if (r < 4) in_ctrl[k] = 5'd2;
        else if (r < 6) in_ctrl[k] = 5'd3;
        else if (r < 9) in_ctrl[k] = {2'b01, 3'($urandom % 8)};
        else            in_ctrl[k] = 5'd0;
        in_rd[k]  = 5'($urandom % 4);
        in_rs1[k] = 5'($urandom % 4);
        in_rs2[k] = 5'($urandom % 4);
        in_imm[k] = ($urandom % 3 == 0) ? 32'd0 : 32'($urandom);
        in_wr[k]  = ($urandom % 4) != 0;
        in_vld[k] = ($urandom % 8) != 0;
      end
      run("R10 random");
    end

    summary();
    $finish;
  end
endmodule